// File: doc/BRIEF.md
# PCM Sample Queue Pair with Threshold Flags and Interrupt Status

This block sits between a register bus and the serial shifter of a PCM audio port. It holds one transmit queue of 16-bit samples, which the bus fills and the shifter drains, and one receive queue, which the shifter fills and the bus drains. Each queue keeps a fill count and reports empty, almost-empty, full and almost-full. One software threshold per queue drives both almost flags and the DMA request for that direction.

Errors are latched when a queue is misused. A push into a full queue is an overflow: the sample is dropped. A pop from an empty queue is a starve. Six sources per direction feed a masked interrupt with a global enable and a pending bit. A clear register acknowledges the latched errors. A command register starts and stops each direction as a single write. The serial side sees a pop strobe with the head sample, and a push strobe with the received sample.

Top module: `pcmq_core`

## Requirements
- R1: After reset the control word reads 0, the queue status word reads 0x300C, the interrupt status reads 0xC30, and irq, both DMA requests and port_active are low.
- R2: A bus write to word 2 with bit 16 set appends bits 15:0 to the transmit queue. A write with bit 16 clear is ignored. tx_sample shows the oldest entry in FIFO order, and tx_sample_vld is high while the queue is not empty.
- R3: A bus read of word 3 returns the oldest receive sample in bits 15:0 with bit 16 set, and removes it from the queue. A read of an empty queue returns bit 16 clear.
- R4: The queue status word (word 4) holds the transmit count in 19:14 and the transmit flags in 13:10 (empty 13, almost-empty 12, full 11, almost-full 10). It holds the receive count in 9:4 and the receive flags in 3:0 in the same order. A queue is full at DEPTH entries.
- R5: With threshold T and count C, almost-empty is C <= T and almost-full is C + T >= DEPTH. The transmit threshold is control bits 18:13 and the receive threshold is control bits 12:7.
- R6: tx_dma_req is high when the transmit queue enable (control bit 2) and transmit DMA enable (bit 6) are both set and the transmit count is <= its threshold. rx_dma_req is high when the receive queue enable (bit 1) and receive DMA enable (bit 5) are both set and the receive count is >= its threshold.
- R7: A push into a full queue drops the sample, leaves the count at DEPTH, and latches that direction's overflow error. Interrupt status bit 6 is transmit overflow and bit 0 is receive overflow.
- R8: A shifter pop of an empty transmit queue latches transmit starve (status bit 7). A bus read of an empty receive queue latches receive starve (status bit 1).
- R9: Interrupt status (word 6) bits 11:8 and 5:2 mirror the live flags in the order of R4. Bit 13 is pending, defined as global enable (word 5 bit 14) AND any source whose enable bit in word 5 bits 11:0 is set. The irq output equals pending.
- R10: Writing word 7 clears each latched error whose bit is 1. Level sources are unaffected. A new error in the same cycle as its clear stays latched.
- R11: Command word 1 bit 0 (transmit start) sets the transmit queue enable, the transmit DMA enable and port enable (control bit 0), and sets the transmit threshold to 32. Bit 2 (receive start) sets the receive queue enable, the receive DMA enable and port enable.
- R12: Command bit 1 (transmit stop) and bit 3 (receive stop) clear that direction's queue and DMA enables. Port enable is cleared only when neither queue enable remains set. A start in the same write takes precedence.
- R13: A queue whose enable is clear holds count 0. Pushes and pops to it are ignored and latch no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at word 3) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the address |
| tx_pop | input | 1 | Shifter takes the head transmit sample |
| tx_sample | output | 16 | Head of the transmit queue |
| tx_sample_vld | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Shifter delivers a received sample |
| rx_sample | input | 16 | Received sample |
| port_active | output | 1 | Port enable bit for the shifter |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The overflow and starve latches are the hardest states to reach: they need a queue filled exactly to DEPTH, or drained to empty, and then one more access. The stimulus gets there by stepping both queues in lock-step from 0 to DEPTH, comparing the status word and the DMA requests with arithmetic at every count. It then pushes once more into both full queues, drains them in order, and makes one extra pop and read. A threshold sweep over every value 0 to 32 at a fixed fill covers the almost-flag boundaries.

// File: rtl/pcmq_pkg.sv
package pcmq_pkg;
    localparam int DW          = 16;
    localparam int CW          = 6;
    localparam int VALID_BIT   = 16;
    localparam int PEND_BIT    = 13;
    localparam int GIE_BIT     = 14;
    localparam int TX_THR_LSB  = 13;
    localparam int RX_THR_LSB  = 7;
    localparam int NSRC        = 12;
    localparam logic [CW-1:0] TX_START_THR = CW'(32);

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_CMD   = 3'd1,
        A_TXQ   = 3'd2,
        A_RXQ   = 3'd3,
        A_FSTAT = 3'd4,
        A_IEN   = 3'd5,
        A_ISTAT = 3'd6,
        A_ICLR  = 3'd7
    } addr_e;

    typedef struct packed {
        logic          port_en;
        logic          tx_fen;
        logic          rx_fen;
        logic          tx_den;
        logic          rx_den;
        logic [CW-1:0] tx_thr;
        logic [CW-1:0] rx_thr;
    } ctl_t;
endpackage

// File: rtl/pcmq_fifo.sv
module pcmq_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [CW-1:0] thr,
    output logic [DW-1:0] head,
    output logic [CW-1:0] cnt,
    output logic          empty,
    output logic          aempty,
    output logic          full,
    output logic          afull,
    output logic          ovf_evt,
    output logic          starve_evt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty      = (s_q.cnt == '0);
    assign full       = (s_q.cnt == CW'(DEPTH));
    assign aempty     = (s_q.cnt <= thr);
    assign afull      = ({1'b0, s_q.cnt} + {1'b0, thr}) >= (CW+1)'(DEPTH);
    assign do_push    = en && push && !full;
    assign do_pop     = en && pop && !empty;
    assign ovf_evt    = en && push && full;
    assign starve_evt = en && pop && empty;
    assign head       = mem_q[s_q.rp];
    assign cnt        = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wp = ptr_inc(s_q.wp);
            if (do_pop)  s_d.rp = ptr_inc(s_q.rp);
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= push_data;
    end
endmodule

// File: rtl/pcmq_irq.sv
module pcmq_irq #(
    parameter int NSRC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      tx_lvl,
    input  logic [3:0]      rx_lvl,
    input  logic            tx_ovf_evt,
    input  logic            tx_starve_evt,
    input  logic            rx_ovf_evt,
    input  logic            rx_starve_evt,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    input  logic [NSRC-1:0] ien,
    input  logic            gie,
    output logic [NSRC-1:0] status,
    output logic            pending
);
    typedef struct packed {
        logic tx_starve;
        logic tx_ovf;
        logic rx_starve;
        logic rx_ovf;
    } err_t;

    err_t e_d, e_q;
    logic [NSRC-1:0] clr;

    assign clr = clr_we ? clr_mask : '0;

    always_comb begin
        e_d.tx_starve = tx_starve_evt || (e_q.tx_starve && !clr[7]);
        e_d.tx_ovf    = tx_ovf_evt    || (e_q.tx_ovf    && !clr[6]);
        e_d.rx_starve = rx_starve_evt || (e_q.rx_starve && !clr[1]);
        e_d.rx_ovf    = rx_ovf_evt    || (e_q.rx_ovf    && !clr[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign status  = {tx_lvl, e_q.tx_starve, e_q.tx_ovf, rx_lvl, e_q.rx_starve, e_q.rx_ovf};
    assign pending = gie && |(status & ien);
endmodule

// File: rtl/pcmq_core.sv
module pcmq_core
    import pcmq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tx_pop,
    output logic [15:0] tx_sample,
    output logic        tx_sample_vld,
    input  logic        rx_push,
    input  logic [15:0] rx_sample,
    output logic        port_active,
    output logic        tx_dma_req,
    output logic        rx_dma_req,
    output logic        irq
);
    typedef struct packed {
        ctl_t            ctl;
        logic [NSRC-1:0] ien;
        logic            gie;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [DW-1:0] tx_head, rx_head;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [3:0]    tx_lvl, rx_lvl;
    logic tx_empty, tx_aempty, tx_full, tx_afull, tx_ovf_evt, tx_starve_evt;
    logic rx_empty, rx_aempty, rx_full, rx_afull, rx_ovf_evt, rx_starve_evt;
    logic [NSRC-1:0] irq_status;
    logic pending;
    logic wr_ctrl, wr_cmd, wr_txq, wr_ien, wr_iclr, rd_rxq;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
    assign wr_txq  = bus_wr && (bus_addr == A_TXQ) && bus_wdata[VALID_BIT];
    assign wr_ien  = bus_wr && (bus_addr == A_IEN);
    assign wr_iclr = bus_wr && (bus_addr == A_ICLR);
    assign rd_rxq  = bus_rd && (bus_addr == A_RXQ);

    pcmq_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .en(regs_q.ctl.tx_fen),
        .push(wr_txq), .push_data(bus_wdata[DW-1:0]), .pop(tx_pop),
        .thr(regs_q.ctl.tx_thr), .head(tx_head), .cnt(tx_cnt),
        .empty(tx_empty), .aempty(tx_aempty), .full(tx_full), .afull(tx_afull),
        .ovf_evt(tx_ovf_evt), .starve_evt(tx_starve_evt)
    );

    pcmq_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .en(regs_q.ctl.rx_fen),
        .push(rx_push), .push_data(rx_sample), .pop(rd_rxq),
        .thr(regs_q.ctl.rx_thr), .head(rx_head), .cnt(rx_cnt),
        .empty(rx_empty), .aempty(rx_aempty), .full(rx_full), .afull(rx_afull),
        .ovf_evt(rx_ovf_evt), .starve_evt(rx_starve_evt)
    );

    assign tx_lvl = {tx_empty, tx_aempty, tx_full, tx_afull};
    assign rx_lvl = {rx_empty, rx_aempty, rx_full, rx_afull};

    pcmq_irq #(.NSRC(NSRC)) irq_i (
        .clk(clk), .rst_n(rst_n), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .tx_ovf_evt(tx_ovf_evt), .tx_starve_evt(tx_starve_evt),
        .rx_ovf_evt(rx_ovf_evt), .rx_starve_evt(rx_starve_evt),
        .clr_we(wr_iclr), .clr_mask(bus_wdata[NSRC-1:0]),
        .ien(regs_q.ien), .gie(regs_q.gie),
        .status(irq_status), .pending(pending)
    );

    // Register next-state: control word, direction commands, interrupt enables
    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.ctl.port_en = bus_wdata[0];
            regs_d.ctl.rx_fen  = bus_wdata[1];
            regs_d.ctl.tx_fen  = bus_wdata[2];
            regs_d.ctl.rx_den  = bus_wdata[5];
            regs_d.ctl.tx_den  = bus_wdata[6];
            regs_d.ctl.rx_thr  = bus_wdata[RX_THR_LSB +: CW];
            regs_d.ctl.tx_thr  = bus_wdata[TX_THR_LSB +: CW];
        end
        if (wr_cmd) begin
            if (bus_wdata[1]) begin
                regs_d.ctl.tx_fen = 1'b0;
                regs_d.ctl.tx_den = 1'b0;
            end
            if (bus_wdata[3]) begin
                regs_d.ctl.rx_fen = 1'b0;
                regs_d.ctl.rx_den = 1'b0;
            end
            if ((bus_wdata[1] || bus_wdata[3]) && !regs_d.ctl.tx_fen && !regs_d.ctl.rx_fen)
                regs_d.ctl.port_en = 1'b0;
            if (bus_wdata[0]) begin
                regs_d.ctl.tx_fen  = 1'b1;
                regs_d.ctl.tx_den  = 1'b1;
                regs_d.ctl.port_en = 1'b1;
                regs_d.ctl.tx_thr  = TX_START_THR;
            end
            if (bus_wdata[2]) begin
                regs_d.ctl.rx_fen  = 1'b1;
                regs_d.ctl.rx_den  = 1'b1;
                regs_d.ctl.port_en = 1'b1;
            end
        end
        if (wr_ien) begin
            regs_d.ien = bus_wdata[NSRC-1:0];
            regs_d.gie = bus_wdata[GIE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[0] = regs_q.ctl.port_en;
                bus_rdata[1] = regs_q.ctl.rx_fen;
                bus_rdata[2] = regs_q.ctl.tx_fen;
                bus_rdata[5] = regs_q.ctl.rx_den;
                bus_rdata[6] = regs_q.ctl.tx_den;
                bus_rdata[RX_THR_LSB +: CW] = regs_q.ctl.rx_thr;
                bus_rdata[TX_THR_LSB +: CW] = regs_q.ctl.tx_thr;
            end
            A_RXQ: begin
                bus_rdata[DW-1:0]  = rx_head;
                bus_rdata[VALID_BIT] = !rx_empty;
            end
            A_FSTAT: begin
                bus_rdata[19:14] = tx_cnt;
                bus_rdata[13:10] = tx_lvl;
                bus_rdata[9:4]   = rx_cnt;
                bus_rdata[3:0]   = rx_lvl;
            end
            A_IEN: begin
                bus_rdata[NSRC-1:0] = regs_q.ien;
                bus_rdata[GIE_BIT]  = regs_q.gie;
            end
            A_ISTAT: begin
                bus_rdata[NSRC-1:0] = irq_status;
                bus_rdata[PEND_BIT] = pending;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign tx_sample     = tx_head;
    assign tx_sample_vld = !tx_empty;
    assign port_active   = regs_q.ctl.port_en;
    assign tx_dma_req    = regs_q.ctl.tx_fen && regs_q.ctl.tx_den && (tx_cnt <= regs_q.ctl.tx_thr);
    assign rx_dma_req    = regs_q.ctl.rx_fen && regs_q.ctl.rx_den && (rx_cnt >= regs_q.ctl.rx_thr);
    assign irq           = pending;
endmodule

// File: rtl/pcmq_core_chk.sv
module pcmq_core_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [2:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          rx_push,
    input logic          irq,
    input logic          tx_dma_req,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_thr,
    input logic          tx_fen,
    input logic          rx_fen,
    input logic          port_en,
    input logic          gie,
    input logic          rx_ovf
);
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    p_dma_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (tx_cnt <= tx_thr));

    p_ovf_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fen && rx_push && rx_cnt == CW'(DEPTH)
         && !(bus_rd && bus_addr == 3'd3)
         && !(bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1)))
        |=> (rx_cnt == CW'(DEPTH)) && rx_ovf);

    p_gie_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

    p_tx_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1 && bus_wdata[0])
        |=> tx_fen && port_en && (tx_thr == CW'(32)));

    p_tx_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1 && bus_wdata[1] && !bus_wdata[0])
        |=> !tx_fen);

    p_off_empty_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_fen |=> (tx_cnt == '0));
endmodule

bind pcmq_core pcmq_core_chk #(.DEPTH(DEPTH), .CW(pcmq_pkg::CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_push(rx_push),
    .irq(irq), .tx_dma_req(tx_dma_req), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_thr(regs_q.ctl.tx_thr), .tx_fen(regs_q.ctl.tx_fen),
    .rx_fen(regs_q.ctl.rx_fen), .port_en(regs_q.ctl.port_en),
    .gie(regs_q.gie), .rx_ovf(irq_status[0])
);

// File: tb/pcmq_core_tb_top.sv
module pcmq_core_tb_top;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_pop = 1'b0;
    logic [15:0] tx_sample;
    logic        tx_sample_vld;
    logic        rx_push = 1'b0;
    logic [15:0] rx_sample = '0;
    logic        port_active, tx_dma_req, rx_dma_req, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pcmq_core #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_pop(tx_pop), .tx_sample(tx_sample), .tx_sample_vld(tx_sample_vld),
        .rx_push(rx_push), .rx_sample(rx_sample), .port_active(port_active),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fstat_exp(input int txc, input int txt, input int rxc, input int rxt);
        logic [3:0] tf, rf;
        tf = {txc == 0, txc <= txt, txc == DEPTH, (txc + txt) >= DEPTH};
        rf = {rxc == 0, rxc <= rxt, rxc == DEPTH, (rxc + rxt) >= DEPTH};
        return (32'(txc) << 14) | (32'(tf) << 10) | (32'(rxc) << 4) | 32'(rf);
    endfunction

    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] wd,
                        input logic push, input logic [15:0] pd, input logic pop);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = wd;
        rx_push = push; rx_sample = pd; tx_pop = pop;
        @(posedge clk); #1;
        bus_wr = 1'b0; rx_push = 1'b0; tx_pop = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] wd);
        step(1'b1, a, wd, 1'b0, 16'h0, 1'b0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #5 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // Peek: read a register with no side effect (never word 3)
    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #5 v = bus_rdata;
    endtask

    localparam logic [31:0] CTRL_ALL = 32'h1 | 32'h2 | 32'h4 | 32'h20 | 32'h40;

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        peek(3'd0, v); check("R1 ctrl", v, 32'h0);
        peek(3'd4, v); check("R1 fstat", v, 32'h300C);
        peek(3'd6, v); check("R1 istat", v, 32'hC30);
        check("R1 outputs", {28'h0, irq, tx_dma_req, rx_dma_req, port_active}, 32'h0);

        // R11 transmit start
        wr(3'd1, 32'h1);
        peek(3'd0, v); check("R11 tx start ctrl", v, 32'h40045);

        // R4/R5/R6 lock-step fill sweep, tx thr 8, rx thr 20
        wr(3'd0, CTRL_ALL | (32'd20 << 7) | (32'd8 << 13));
        for (int k = 0; k <= DEPTH; k++) begin
            peek(3'd4, v); check("R4 fill sweep fstat", v, fstat_exp(k, 8, k, 20));
            check("R6 tx dma sweep", {31'h0, tx_dma_req}, {31'h0, k <= 8});
            check("R6 rx dma sweep", {31'h0, rx_dma_req}, {31'h0, k >= 20});
            if (k < DEPTH)
                step(1'b1, 3'd2, 32'h10000 | (32'hA000 + k), 1'b1, 16'(16'h5000 + 3*k), 1'b0);
        end

        // R7 overflow on both queues
        step(1'b1, 3'd2, 32'h1FFFF, 1'b1, 16'hFFFF, 1'b0);
        peek(3'd4, v); check("R7 counts stay full", v, fstat_exp(32, 8, 32, 20));
        peek(3'd6, v); check("R7 overflow latched", v, 32'h34D);

        // R2 transmit drain order
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            check("R2 tx order", {15'h0, tx_sample_vld, tx_sample}, 32'h10000 | (32'hA000 + k));
            step(1'b0, 3'd0, 32'h0, 1'b0, 16'h0, 1'b1);
        end
        // R3 receive drain order
        for (int k = 0; k < DEPTH; k++) begin
            rd(3'd3, v);
            check("R3 rx order", v, 32'h10000 | 32'(16'(16'h5000 + 3*k)));
        end

        // R8 starve on both
        step(1'b0, 3'd0, 32'h0, 1'b0, 16'h0, 1'b1);
        rd(3'd3, v); check("R3 empty read valid bit", {31'h0, v[16]}, 32'h0);
        peek(3'd6, v); check("R8 starve latched", v, 32'hCF3);

        // R9 interrupt masking
        wr(3'd5, 32'h80);
        peek(3'd6, v); check("R9 no gie pending", {31'h0, v[13]}, 32'h0);
        check("R9 no gie irq", {31'h0, irq}, 32'h0);
        wr(3'd5, 32'h4080);
        peek(3'd6, v); check("R9 pending set", v, 32'h2CF3);
        check("R9 irq set", {31'h0, irq}, 32'h1);
        // R10 clear latched
        wr(3'd7, 32'hC3);
        peek(3'd6, v); check("R10 cleared", v, 32'hC30);
        check("R10 irq low", {31'h0, irq}, 32'h0);
        wr(3'd5, 32'h4800);
        check("R9 level irq", {31'h0, irq}, 32'h1);
        wr(3'd7, 32'h800);
        check("R10 level not cleared", {31'h0, irq}, 32'h1);
        wr(3'd5, 32'h0);

        // R2 write without valid bit ignored
        wr(3'd2, 32'h1234);
        peek(3'd4, v); check("R2 invalid write ignored", v, fstat_exp(0, 8, 0, 20));

        // R5 threshold sweep at count 10
        for (int k = 0; k < 10; k++) wr(3'd2, 32'h10000 | 32'(k));
        for (int t = 0; t <= 32; t++) begin
            wr(3'd0, CTRL_ALL | (32'd20 << 7) | (32'(t) << 13));
            peek(3'd4, v); check("R5 thr sweep fstat", v, fstat_exp(10, t, 0, 20));
            check("R6 thr sweep tx dma", {31'h0, tx_dma_req}, {31'h0, 10 <= t});
        end

        // R12 stops
        wr(3'd1, 32'h2);
        peek(3'd0, v); check("R12 tx stop ctrl", v, 32'h40A23);
        check("R12 port kept", {31'h0, port_active}, 32'h1);
        peek(3'd4, v); check("R13 tx flushed", v, fstat_exp(0, 32, 0, 20));
        wr(3'd1, 32'h8);
        peek(3'd0, v); check("R12 rx stop ctrl", v, 32'h40A00);
        check("R12 port off", {31'h0, port_active}, 32'h0);

        // R13 disabled queues ignore traffic
        step(1'b1, 3'd2, 32'h1ABCD, 1'b1, 16'h7777, 1'b1);
        rd(3'd3, v);
        peek(3'd4, v); check("R13 counts zero", v, fstat_exp(0, 32, 0, 20));
        peek(3'd6, v); check("R13 no errors", v, 32'hD30);

        // R11 receive start then transmit start
        wr(3'd0, (32'd20 << 7) | (32'd5 << 13));
        wr(3'd1, 32'h4);
        peek(3'd0, v); check("R11 rx start ctrl", v, 32'hAA23);
        wr(3'd1, 32'h1);
        peek(3'd0, v); check("R11 tx start thr", v, 32'h40A67);
        check("R11 port on", {31'h0, port_active}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule